// File: doc/BRIEF.md
# UART Multiprocessor Address Filter

This block sits behind a UART receiver that delivers complete frames and decides, frame by frame, whether software should be told a byte has arrived. On a bus shared by several stations, each station is given a station address and a mask. A frame whose ninth bit is 1 carries an address. The filter compares that address with two patterns. The first is a masked unicast pattern, in which mask bits of 0 are ignored. The second is a broadcast pattern formed as the bitwise OR of address and mask, in which zero bits are ignored. Only a matching address frame raises the receive flag. Data frames (ninth bit 0) are dropped while filtering is active.

Filtering takes effect only when the filter-enable input is set and the port runs in a 9-bit mode. Otherwise every valid frame is passed through. The receive flag is sticky until software clears it. The captured byte holds the data bits of the last frame that was accepted.

Top module: `uart_addr_filter`

## Requirements
- R1: With filtering active and ninth bit 1, a frame is accepted when every bit position whose mask bit is 1 holds the same value in the frame data as in the station address. Positions whose mask bit is 0 are ignored.
- R2: With filtering active and ninth bit 1, a frame is also accepted when the frame data has a 1 in every position where (address OR mask) is 1. Positions where that OR is 0 are ignored.
- R3: With address and mask both all zeros, every address frame is accepted while filtering is active.
- R4: Filtering is active only when `filt_en`=1 and `nine_bit_mode`=1. In every other combination, each valid frame sets the flag and is captured, whatever its ninth bit.
- R5: With filtering active, a frame whose ninth bit is 0 neither sets the flag nor changes the captured byte.
- R6: With filtering active, an address frame that matches neither pattern neither sets the flag nor changes the captured byte.
- R7: With address 8'b1100_0000 and mask 8'b1111_1101, the address byte 8'b1100_0010 is accepted. With mask 8'b1111_1110, the same byte is rejected.
- R8: `rx_flag` stays at 1 until `flag_clr` is pulsed. A further accepted frame while the flag is set overwrites `rx_byte` and leaves the flag at 1.
- R9: `rx_flag` and `rx_byte` change on the first rising clock edge at which `frm_valid` is sampled high, so they are visible exactly one clock after the strobe.
- R10: If `flag_clr` and an accepted frame occur in the same cycle, the flag ends up set. `flag_clr` alone clears the flag on the next edge.
- R11: After reset, `rx_flag` is 0 and `rx_byte` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | One-cycle strobe marking a received frame |
| frm_data | input | DW | Eight (DW) data bits of the frame |
| frm_bit9 | input | 1 | Ninth bit of the frame; 1 marks an address |
| filt_en | input | 1 | Address filter enable |
| nine_bit_mode | input | 1 | Port is in a 9-bit frame mode |
| stn_addr | input | DW | Station address |
| stn_mask | input | DW | Station address mask |
| flag_clr | input | 1 | Software clear of the receive flag |
| rx_flag | output | 1 | Sticky receive flag |
| rx_byte | output | DW | Data bits of the last accepted frame |

## Verification
The bench builds two copies, one with DW=8 and one with DW=4, and drives them with the same frames. The 4-bit copy makes an exhaustive sweep possible: every address, mask, data value and ninth bit under active filtering is tried, which covers all the ways the unicast and broadcast patterns can overlap, plus every inactive mode combination. In that sweep the 8-bit copy sees zeros in its upper address and mask bits, so it must give the same verdict. The 8-bit width is kept for the worked two-slave example and the sticky-flag sequences.

// File: rtl/uaf_pkg.sv
package uaf_pkg;
   typedef struct packed {
      logic given;
      logic bcast;
   } uaf_hit_t;
endpackage

// File: rtl/uaf_match.sv
module uaf_match #(
   parameter int DW = 8
) (
   input  logic [DW-1:0]   data,
   input  logic [DW-1:0]   addr,
   input  logic [DW-1:0]   mask,
   output uaf_pkg::uaf_hit_t hit
);
   logic [DW-1:0] given_ok;
   logic [DW-1:0] bcast_ok;
   logic [DW-1:0] bpat;

   assign bpat = addr | mask;

   for (genvar i = 0; i < DW; i++) begin : g_bit
      // masked-off positions are free; others must equal the address
      assign given_ok[i] = ~mask[i] | ~(data[i] ^ addr[i]);
      // broadcast positions that are 0 are free; others need a 1
      assign bcast_ok[i] = ~bpat[i] | data[i];
   end

   assign hit.given = &given_ok;
   assign hit.bcast = &bcast_ok;
endmodule

// File: rtl/uaf_qualify.sv
module uaf_qualify (
   input  logic               bit9,
   input  logic               filt_en,
   input  logic               nine_bit_mode,
   input  uaf_pkg::uaf_hit_t  hit,
   output logic               accept
);
   logic active;

   always_comb begin
      active = filt_en & nine_bit_mode;
      if (!active) accept = 1'b1;
      else         accept = bit9 & (hit.given | hit.bcast);
   end
endmodule

// File: rtl/uaf_hold.sv
module uaf_hold #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          clr,
   input  logic [DW-1:0] din,
   output logic          flag,
   output logic [DW-1:0] dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         dout <= '0;
      end else begin
         if (take) begin
            flag <= 1'b1;
            dout <= din;
         end else if (clr) begin
            flag <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/uart_addr_filter.sv
module uart_addr_filter #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frm_valid,
   input  logic [DW-1:0] frm_data,
   input  logic          frm_bit9,
   input  logic          filt_en,
   input  logic          nine_bit_mode,
   input  logic [DW-1:0] stn_addr,
   input  logic [DW-1:0] stn_mask,
   input  logic          flag_clr,
   output logic          rx_flag,
   output logic [DW-1:0] rx_byte
);
   initial begin
      if (DW < 1 || DW > 32) $error("uart_addr_filter: DW out of range");
   end

   uaf_pkg::uaf_hit_t hit;
   logic              accept;

   uaf_match #(.DW(DW)) u_match (
      .data (frm_data),
      .addr (stn_addr),
      .mask (stn_mask),
      .hit  (hit)
   );

   uaf_qualify u_qual (
      .bit9          (frm_bit9),
      .filt_en       (filt_en),
      .nine_bit_mode (nine_bit_mode),
      .hit           (hit),
      .accept        (accept)
   );

   uaf_hold #(.DW(DW)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (frm_valid & accept),
      .clr   (flag_clr),
      .din   (frm_data),
      .flag  (rx_flag),
      .dout  (rx_byte)
   );
endmodule

// File: rtl/uaf_checker.sv
module uaf_checker #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          frm_valid,
   input logic [DW-1:0] frm_data,
   input logic          frm_bit9,
   input logic          filt_en,
   input logic          nine_bit_mode,
   input logic          flag_clr,
   input logic          rx_flag,
   input logic [DW-1:0] rx_byte
);
   // R9
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_flag) |-> $past(frm_valid));

   // R5
   data_frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && filt_en && nine_bit_mode && !frm_bit9)
      |=> (rx_byte == $past(rx_byte)));

   // R4
   pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && !(filt_en && nine_bit_mode))
      |=> (rx_flag && rx_byte == $past(frm_data)));

   // R8
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_flag && !flag_clr) |=> rx_flag);

   // R10
   clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !frm_valid) |=> !rx_flag);

   // R9
   byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid |=> $stable(rx_byte));
endmodule

bind uart_addr_filter uaf_checker #(.DW(DW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .frm_valid     (frm_valid),
   .frm_data      (frm_data),
   .frm_bit9      (frm_bit9),
   .filt_en       (filt_en),
   .nine_bit_mode (nine_bit_mode),
   .flag_clr      (flag_clr),
   .rx_flag       (rx_flag),
   .rx_byte       (rx_byte)
);

// File: tb/sim_uart_addr_filter.sv
module sim_uart_addr_filter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fv = 1'b0;
   logic [7:0] d = '0;
   logic [7:0] a = '0;
   logic [7:0] m = '0;
   logic       b9 = 1'b0;
   logic       fen = 1'b0;
   logic       m9 = 1'b0;
   logic       fclr = 1'b0;
   logic       flag8, flag4;
   logic [7:0] byte8;
   logic [3:0] byte4;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   logic       ef  = 1'b0;
   logic [7:0] eb8 = '0;
   logic [3:0] eb4 = '0;

   always #10 clk = ~clk;

   uart_addr_filter #(.DW(8)) u0 (
      .clk(clk), .rst_n(rst_n), .frm_valid(fv), .frm_data(d), .frm_bit9(b9),
      .filt_en(fen), .nine_bit_mode(m9), .stn_addr(a), .stn_mask(m),
      .flag_clr(fclr), .rx_flag(flag8), .rx_byte(byte8));

   uart_addr_filter #(.DW(4)) u1 (
      .clk(clk), .rst_n(rst_n), .frm_valid(fv), .frm_data(d[3:0]), .frm_bit9(b9),
      .filt_en(fen), .nine_bit_mode(m9), .stn_addr(a[3:0]), .stn_mask(m[3:0]),
      .flag_clr(fclr), .rx_flag(flag4), .rx_byte(byte4));

   function automatic bit model(input [7:0] aa, mm, dd, input bb, en, nm);
      logic [7:0] bp;
      bp = aa | mm;
      if (!(en && nm)) return 1'b1;
      return bb && ((((dd ^ aa) & mm) == 8'h00) || ((dd & bp) == bp));
   endfunction

   task automatic chk(input string r, input logic [7:0] got, input logic [7:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h", r, got, exp);
      end
   endtask

   task automatic send(input [7:0] aa, mm, dd, input bb, en, nm, cl);
      @(negedge clk);
      a = aa; m = mm; d = dd; b9 = bb; fen = en; m9 = nm; fclr = cl; fv = 1'b1;
      if (model(aa, mm, dd, bb, en, nm)) begin
         ef = 1'b1; eb8 = dd; eb4 = dd[3:0];
      end else if (cl) begin
         ef = 1'b0;
      end
      @(negedge clk);
      fv = 1'b0; fclr = 1'b0;
   endtask

   task automatic clear_flag();
      @(negedge clk);
      fclr = 1'b1;
      @(negedge clk);
      fclr = 1'b0;
      ef = 1'b0;
      chk("R10 clear", {7'd0, flag8}, 8'd0);
   endtask

   task automatic verify(input string r);
      chk(r, {7'd0, flag8}, {7'd0, ef});
      chk(r, byte8, eb8);
      chk(r, {7'd0, flag4}, {7'd0, ef});
      chk(r, {4'd0, byte4}, {4'd0, eb4});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 reset flag", {7'd0, flag8}, 8'd0);
      chk("R11 reset byte", byte8, 8'd0);
      rst_n = 1'b1;

      // R7 worked example
      send(8'hC0, 8'hFD, 8'hC2, 1'b1, 1'b1, 1'b1, 1'b0);
      chk("R7 accept", {7'd0, flag8}, 8'd1);
      chk("R7 byte", byte8, 8'hC2);
      clear_flag();
      send(8'hC0, 8'hFE, 8'hC2, 1'b1, 1'b1, 1'b1, 1'b0);
      chk("R7 reject", {7'd0, flag8}, 8'd0);
      chk("R6 byte kept", byte8, 8'hC2);

      // R9 timing: flag still low just after strobe is driven
      @(negedge clk);
      a = 8'h00; m = 8'h00; d = 8'h5A; b9 = 1'b1; fen = 1'b1; m9 = 1'b1; fv = 1'b1;
      #1 chk("R9 before edge", {7'd0, flag8}, 8'd0);
      @(negedge clk);
      fv = 1'b0;
      chk("R9 after edge", {7'd0, flag8}, 8'd1);
      chk("R3 zero regs", byte8, 8'h5A);
      ef = 1'b1; eb8 = 8'h5A; eb4 = 4'hA;

      // R8 sticky and overwrite
      repeat (3) @(negedge clk);
      chk("R8 sticky", {7'd0, flag8}, 8'd1);
      send(8'h00, 8'h00, 8'h33, 1'b1, 1'b1, 1'b1, 1'b0);
      verify("R8 overwrite");
      send(8'h00, 8'h00, 8'h77, 1'b0, 1'b1, 1'b1, 1'b0);
      verify("R5 data frame");

      // R10 clear together with an accepted frame
      send(8'h00, 8'h00, 8'h11, 1'b1, 1'b1, 1'b1, 1'b1);
      verify("R10 set wins");
      clear_flag();

      // R4 inactive combinations
      for (int mode = 0; mode < 3; mode++) begin
         for (int v = 0; v < 32; v++) begin
            send(8'hFF, 8'hFF, 8'(v * 7), v[4], mode[0], mode[1], 1'b0);
            verify("R4 pass through");
            clear_flag();
         end
      end

      // R1 R2 R5 R6 exhaustive 4-bit sweep under active filtering
      for (int ai = 0; ai < 16; ai++) begin
         for (int mi = 0; mi < 16; mi++) begin
            for (int di = 0; di < 32; di++) begin
               send(8'(ai), 8'(mi), 8'(di[3:0]), di[4], 1'b1, 1'b1, 1'b0);
               verify("R1 R2 R6 sweep");
               if (ef) clear_flag();
            end
         end
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog got=timeout exp=completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule